// File: doc/BRIEF.md
# Memory-Controller Event Counter Unit

This block counts traffic and command events from a DRAM controller. Eight 32-bit counters each have one event pulse wired to them. Counter k counts only event k, and no register selects the event type. The event wired to each index is as follows:

| Index | Event |
|---|---|
| 0 | write data beats |
| 1 | read data beats |
| 2 | write commands |
| 3 | read commands |
| 4 | precharge commands |
| 5 | activate commands |
| 6 | rank switches |
| 7 | read/write turnarounds |

Software uses a simple register port with a read strobe and a write strobe. Through it, software reads and preloads each counter and sets a global run bit and a per-counter enable mask.

A counter that wraps from all-ones to zero raises a sticky overflow flag. Flags are cleared by writing 1s to a clear register. A per-counter mask decides which flags drive the single level interrupt. Because counters can be preloaded, software can set the interval until the next interrupt and use the unit for sampling.

Top module: `mc_evt_monitor`

## Requirements
- R1: After reset, the following hold: every counter reads 0, the control register reads 0, the enable mask reads 0, the status register reads 0, the interrupt mask reads 0x000000FF and `irq_o` is low.
- R2: Counter k rises by exactly one on each clock edge where three conditions hold: `evt_pulse[k]` is high, enable-mask bit k is 1, and the global run bit is 1. No other event input changes counter k.
- R3: The register map is as follows. Counters 0-3 are at 0x380, 0x384, 0x388 and 0x38C. Counters 4-5 are at 0x3C0 and 0x3C4. Counters 6-7 are at 0x3CC and 0x3D0. The control register is at 0x010. The enable mask is at 0x6C0, interrupt mask at 0x6C8, status at 0x6CC and clear at 0x6D0. The mask registers use bits [7:0], with bit k belonging to counter k. `reg_rdata` shows the addressed register while `reg_rd` is high, in the same cycle, and is 0 at unmapped offsets.
- R4: The global run bit is bit 1 of the control register. While it is 0, no counter advances. The other control bits are plain read/write storage.
- R5: A write to a counter offset loads `reg_wdata` into that counter. If an increment of the same counter falls on the same edge, the write wins.
- R6: A counter that advances from 0xFFFFFFFF goes to 0 and sets its status bit on that same edge. The counter keeps counting afterwards.
- R7: `irq_o` is the OR over k of (status bit k AND NOT interrupt-mask bit k). A status bit is set even while its interrupt is masked.
- R8: Writing 1 to bit k of the clear register clears status bit k, and 0 bits leave their status bits unchanged. Writes to the status offset have no effect. When a wrap and a clear of the same bit fall on the same edge, the bit ends up set.
- R9: The clear register reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_pulse | input | 8 | One event strobe per counter, counted when high at an edge |
| reg_wr | input | 1 | Write strobe, acts on the clock edge |
| reg_rd | input | 1 | Read strobe, qualifies `reg_rdata` |
| reg_addr | input | 12 | Byte offset of the accessed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the registers |
| irq_o | output | 1 | Level interrupt for unmasked overflows |

## Verification
An error in a counter's enable path can be seen at the next read of that counter, one edge after the faulty pulse. The bench reads counters after short pulse bursts under different enable patterns, so a wrong count shows up quickly. An error in the status flags reaches `irq_o` in the same cycle it is made, because the interrupt is combinational from the status and mask state. For the same reason, wrap and clear conflicts are checked on the edge right after they happen. A corrupted mask or a failed clear shows up as a wrong `irq_o` level before any further events occur.

// File: rtl/mcm_pkg.sv
// Package: shared sizes and the register offsets of the event counter unit.
// Assumes a byte-addressed register port with 32-bit registers.
package mcm_pkg;
    parameter int NUM_CNT = 8;
    parameter int CNT_W   = 32;
    parameter int DATA_W  = 32;
    parameter int ADDR_W  = 12;
    parameter int RUN_BIT = 1;

    localparam logic [ADDR_W-1:0] OFF_CTRL   = 12'h010;
    localparam logic [ADDR_W-1:0] OFF_EN     = 12'h6C0;
    localparam logic [ADDR_W-1:0] OFF_MASK   = 12'h6C8;
    localparam logic [ADDR_W-1:0] OFF_STATUS = 12'h6CC;
    localparam logic [ADDR_W-1:0] OFF_CLEAR  = 12'h6D0;

    // Offset of counter k; the spacing is irregular, so it is listed per index.
    function automatic logic [ADDR_W-1:0] cnt_offset(input int k);
        case (k)
            0:       return 12'h380;
            1:       return 12'h384;
            2:       return 12'h388;
            3:       return 12'h38C;
            4:       return 12'h3C0;
            5:       return 12'h3C4;
            6:       return 12'h3CC;
            default: return 12'h3D0;
        endcase
    endfunction
endpackage

// File: rtl/mcm_counter.sv
// Module: one event counter with a software load port.
// A load takes priority over an increment on the same edge. The wrap flag
// is high in the cycle whose increment moves the counter from all-ones to zero.
module mcm_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    // Counter state: the load wins, otherwise step by one.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (ld)  cnt <= ld_val;
        else if (inc) cnt <= cnt + 1'b1;
    end

    // Wrap detection for the overflow logic.
    always_comb wrap = inc && !ld && (cnt == {W{1'b1}});
endmodule

// File: rtl/mcm_regdecode.sv
// Module: address decode for writes and the read multiplexer.
// Assumes the strobes are single-cycle qualified and the offsets are exact.
module mcm_regdecode
    import mcm_pkg::*;
(
    input  logic                           reg_wr,
    input  logic                           reg_rd,
    input  logic [ADDR_W-1:0]              reg_addr,
    input  logic [NUM_CNT-1:0][CNT_W-1:0]  cnt_arr,
    input  logic [DATA_W-1:0]              ctrl_q,
    input  logic [NUM_CNT-1:0]             en_q,
    input  logic [NUM_CNT-1:0]             mask_q,
    input  logic [NUM_CNT-1:0]             status_q,
    output logic [NUM_CNT-1:0]             cnt_wr,
    output logic                           ctrl_wr,
    output logic                           en_wr,
    output logic                           mask_wr,
    output logic                           clr_wr,
    output logic [DATA_W-1:0]              reg_rdata
);
    localparam int PAD = DATA_W - NUM_CNT;

    // Write strobes for each counter offset.
    for (genvar k = 0; k < NUM_CNT; k++) begin : g_cwr
        assign cnt_wr[k] = reg_wr && (reg_addr == cnt_offset(k));
    end

    // Write strobes for the control-type registers.
    always_comb begin
        ctrl_wr = reg_wr && (reg_addr == OFF_CTRL);
        en_wr   = reg_wr && (reg_addr == OFF_EN);
        mask_wr = reg_wr && (reg_addr == OFF_MASK);
        clr_wr  = reg_wr && (reg_addr == OFF_CLEAR);
    end

    // Read mux: zero for unmapped offsets and for the clear register.
    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            for (int k = 0; k < NUM_CNT; k++)
                if (reg_addr == cnt_offset(k)) reg_rdata = cnt_arr[k];
            if (reg_addr == OFF_CTRL)   reg_rdata = ctrl_q;
            if (reg_addr == OFF_EN)     reg_rdata = {{PAD{1'b0}}, en_q};
            if (reg_addr == OFF_MASK)   reg_rdata = {{PAD{1'b0}}, mask_q};
            if (reg_addr == OFF_STATUS) reg_rdata = {{PAD{1'b0}}, status_q};
        end
    end
endmodule

// File: rtl/mcm_ovf_irq.sv
// Module: sticky overflow flags, interrupt mask and the interrupt output.
// When a wrap and a write-1-to-clear hit the same bit, the wrap wins.
module mcm_ovf_irq #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] wrap,
    input  logic         clr_wr,
    input  logic         mask_wr,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] status_q,
    output logic [N-1:0] mask_q,
    output logic         irq_o
);
    logic [N-1:0] clr_bits;

    // Clear request bits, active only on a write to the clear offset.
    always_comb clr_bits = clr_wr ? wdata : '0;

    // Sticky status: clear first, then let wraps set.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_bits) | wrap;
    end

    // Interrupt mask, all bits blocking out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '1;
        else if (mask_wr) mask_q <= wdata;
    end

    // Level interrupt from unmasked flags.
    always_comb irq_o = |(status_q & ~mask_q);
endmodule

// File: rtl/mc_evt_monitor.sv
// Module: top of the memory-controller event counter unit.
// Holds the control and enable registers, eight fixed-event counters,
// the decode and the overflow logic. Assumes the event pulses are synchronous to clk.
module mc_evt_monitor
    import mcm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        evt_pulse,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [11:0]       reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq_o
);
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_arr;
    logic [NUM_CNT-1:0]            cnt_wr;
    logic [NUM_CNT-1:0]            cnt_inc;
    logic [NUM_CNT-1:0]            wrap;
    logic [DATA_W-1:0]             ctrl_q;
    logic [NUM_CNT-1:0]            en_q;
    logic [NUM_CNT-1:0]            mask_q;
    logic [NUM_CNT-1:0]            status_q;
    logic                          ctrl_wr, en_wr, mask_wr, clr_wr;
    logic                          run;

    // Control register; the run bit gates all counting.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= reg_wdata;
    end

    // Per-counter enable mask.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_wr) en_q <= reg_wdata[NUM_CNT-1:0];
    end

    // Increment qualifier per counter.
    always_comb begin
        run     = ctrl_q[RUN_BIT];
        cnt_inc = evt_pulse & en_q & {NUM_CNT{run}};
    end

    for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
        mcm_counter #(.W(CNT_W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .inc    (cnt_inc[k]),
            .ld     (cnt_wr[k]),
            .ld_val (reg_wdata[CNT_W-1:0]),
            .cnt    (cnt_arr[k]),
            .wrap   (wrap[k])
        );
    end

    mcm_regdecode u_dec (
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .cnt_arr   (cnt_arr),
        .ctrl_q    (ctrl_q),
        .en_q      (en_q),
        .mask_q    (mask_q),
        .status_q  (status_q),
        .cnt_wr    (cnt_wr),
        .ctrl_wr   (ctrl_wr),
        .en_wr     (en_wr),
        .mask_wr   (mask_wr),
        .clr_wr    (clr_wr),
        .reg_rdata (reg_rdata)
    );

    mcm_ovf_irq #(.N(NUM_CNT)) u_ovf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wrap     (wrap),
        .clr_wr   (clr_wr),
        .mask_wr  (mask_wr),
        .wdata    (reg_wdata[NUM_CNT-1:0]),
        .status_q (status_q),
        .mask_q   (mask_q),
        .irq_o    (irq_o)
    );
endmodule

// File: rtl/mcm_checker.sv
// Module: assertion checker bound to the top of the event counter unit.
module mcm_checker
    import mcm_pkg::*;
(
    input logic                          clk,
    input logic                          rst_n,
    input logic [NUM_CNT-1:0]            evt_pulse,
    input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_arr,
    input logic [NUM_CNT-1:0]            cnt_wr,
    input logic [NUM_CNT-1:0]            en_q,
    input logic [DATA_W-1:0]             ctrl_q,
    input logic [NUM_CNT-1:0]            mask_q,
    input logic [NUM_CNT-1:0]            status_q,
    input logic                          clr_wr,
    input logic [NUM_CNT-1:0]            clr_data,
    input logic                          irq_o
);
    // R4: with the run bit low and no counter write, all counters hold.
    a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[RUN_BIT] && cnt_wr == '0) |=> $stable(cnt_arr));

    // R7: a fully masked unit never interrupts.
    a_r7_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '1) |-> !irq_o);

    // R8: set flags survive unless a clear names them.
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & $past(status_q & ~(clr_wr ? clr_data : '0)))
                  == $past(status_q & ~(clr_wr ? clr_data : '0))));

    for (genvar k = 0; k < NUM_CNT; k++) begin : g_chk
        // R6: an enabled step from all-ones sets the flag and lands on zero.
        a_r6_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl_q[RUN_BIT] && en_q[k] && evt_pulse[k] && !cnt_wr[k]
             && cnt_arr[k] == {CNT_W{1'b1}}) |=> (status_q[k] && cnt_arr[k] == '0));
        // R2: a disabled counter without a write does not move.
        a_r2_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_q[k] && !cnt_wr[k]) |=> $stable(cnt_arr[k]));
    end
endmodule

bind mc_evt_monitor mcm_checker u_mcm_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_pulse (evt_pulse),
    .cnt_arr   (cnt_arr),
    .cnt_wr    (cnt_wr),
    .en_q      (en_q),
    .ctrl_q    (ctrl_q),
    .mask_q    (mask_q),
    .status_q  (status_q),
    .clr_wr    (clr_wr),
    .clr_data  (reg_wdata[7:0]),
    .irq_o     (irq_o)
);

// File: tb/mc_evt_monitor_bench.sv
// Directed bench for the event counter unit: one task per scenario.
module mc_evt_monitor_bench;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [7:0]  evt_pulse = '0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_o;
    int          n_run = 0, n_fail = 0;

    mc_evt_monitor u_mc_evt_monitor (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_o(irq_o));

    always #10 clk = ~clk;

    function automatic logic [11:0] coff(input int k);
        logic [11:0] t [8] = '{12'h380, 12'h384, 12'h388, 12'h38C,
                               12'h3C0, 12'h3C4, 12'h3CC, 12'h3D0};
        return t[k];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1; reg_addr = a;
        #1 d = reg_rdata;
        reg_rd = 0;
    endtask

    task automatic pulse(input logic [7:0] m, input int n);
        @(negedge clk); evt_pulse = m;
        repeat (n) @(negedge clk);
        evt_pulse = '0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int k = 0; k < 8; k++) begin rd(coff(k), v); check("R1 counter", v, 0); end
        rd(12'h010, v); check("R1 ctrl", v, 0);
        rd(12'h6C0, v); check("R1 enable", v, 0);
        rd(12'h6C8, v); check("R1 mask", v, 32'hFF);
        rd(12'h6CC, v); check("R1 status", v, 0);
        check("R1 irq", irq_o, 0);
    endtask

    task automatic t_run_off();
        logic [31:0] v;
        wr(12'h6C0, 32'hFF);
        wr(12'h010, 32'hA5A5_0001);
        pulse(8'hFF, 5);
        for (int k = 0; k < 8; k++) begin rd(coff(k), v); check("R4 held", v, 0); end
        rd(12'h010, v); check("R4 ctrl storage", v, 32'hA5A5_0001);
    endtask

    task automatic t_enable_mask();
        logic [31:0] v;
        wr(12'h010, 32'h2);
        wr(12'h6C0, 32'h05);
        pulse(8'hFF, 3);
        rd(coff(0), v); check("R2 cnt0", v, 3);
        rd(coff(1), v); check("R2 cnt1 disabled", v, 0);
        rd(coff(2), v); check("R2 cnt2", v, 3);
        wr(12'h6C0, 32'hFF);
        pulse(8'h02, 4);
        rd(coff(1), v); check("R2 cnt1 own event", v, 4);
        rd(coff(0), v); check("R2 cnt0 isolated", v, 3);
        rd(12'h3C8, v); check("R3 unmapped", v, 0);
        rd(12'h6D0, v); check("R9 clear reads 0", v, 0);
    endtask

    task automatic t_overflow();
        logic [31:0] v;
        wr(coff(3), 32'hFFFF_FFFE);
        rd(coff(3), v); check("R5 preload", v, 32'hFFFF_FFFE);
        pulse(8'h08, 3);
        rd(coff(3), v); check("R6 wrapped and continued", v, 1);
        rd(12'h6CC, v); check("R6 status", v, 32'h08);
        check("R7 masked irq low", irq_o, 0);
        wr(12'h6C8, 32'hF7);
        check("R7 unmasked irq", irq_o, 1);
        wr(12'h6D0, 32'hF7);
        rd(12'h6CC, v); check("R8 zero bits ignored", v, 32'h08);
        wr(12'h6CC, 32'h0);
        rd(12'h6CC, v); check("R8 status not writable", v, 32'h08);
        wr(12'h6D0, 32'h08);
        rd(12'h6CC, v); check("R8 cleared", v, 0);
        check("R7 irq drops", irq_o, 0);
    endtask

    task automatic t_conflicts();
        logic [31:0] v;
        @(negedge clk); evt_pulse = 8'h20; reg_wr = 1; reg_addr = coff(5); reg_wdata = 100;
        @(negedge clk); evt_pulse = 0; reg_wr = 0;
        rd(coff(5), v); check("R5 write wins", v, 100);
        wr(coff(6), 32'hFFFF_FFFF);
        @(negedge clk); evt_pulse = 8'h40; reg_wr = 1; reg_addr = 12'h6D0; reg_wdata = 32'h40;
        @(negedge clk); evt_pulse = 0; reg_wr = 0;
        rd(12'h6CC, v); check("R8 set wins", v, 32'h40);
        rd(coff(6), v); check("R6 wrap to zero", v, 0);
        pulse(8'h40, 2);
        rd(coff(6), v); check("R6 continues", v, 2);
    endtask

    initial begin
        #200000000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_run_off();
        t_enable_mask();
        t_overflow();
        t_conflicts();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule